// File: doc/BRIEF.md
# SPI Channel DMA Request and Interrupt Generator

This block sits beside the channels of a multi-channel SPI controller and decides, every cycle, whether each channel should ask a DMA engine to write its next transmit word or to read a received word. It also keeps the interrupt status of the controller and drives the one interrupt line. Each request is qualified by the channel enable, the per-direction DMA enable, the transfer mode and the single-word buffer flags. The channel that currently owns the shared FIFO uses a further level check: its transmit side must be at or below a programmable almost-empty level, and its receive side at or above a programmable almost-full level.

Interrupt status bits are set from the same qualified conditions and from a word-count-done pulse. Software clears them by writing ones, and a mask selects which bits reach the interrupt line. A small two-state sequencer handles a diagnostic mode. In state `ST_RUN`, status is set by events and cleared by software. In state `ST_TEST`, every implemented status bit is held at one and clears are ignored. The transition `ST_RUN -> ST_TEST` is taken when the test input is high. The transition `ST_TEST -> ST_RUN` is taken when it is low. Both states otherwise hold.

Top module: `spi_dma_irq_gen`

## Requirements
- R1: tx_dreq_o[n] is high one clock after a cycle in which channel n is enabled, its transmit DMA enable is high, its TX-empty flag is high, its mode is not receive-only, and the FIFO level check of R3 passes. Otherwise it is low. Mode encoding: 0 is full duplex, 1 is receive-only, 2 is transmit-only, and 3 behaves like 0.
- R2: rx_dreq_o[n] is high one clock after a cycle in which channel n is enabled, its receive DMA enable is high, its RX-full flag is high, its mode is not transmit-only (2), and the check of R4 passes. Turbo does not affect it.
- R3: When the FIFO owner is valid and equals channel n and the transmit FIFO is enabled, the transmit side of channel n also needs tx_fifo_lvl_i <= ae_thr_i. For every other channel, or with the transmit FIFO disabled, the level is ignored.
- R4: When the FIFO owner is valid and equals channel n and the receive FIFO is enabled, the receive side of channel n also needs rx_fifo_lvl_i >= af_thr_i. Otherwise the level is ignored.
- R5: Status bit 4n (TX empty) is set one clock after a cycle in which channel n is enabled, TX-empty is high, its mode is not 1, and R3 passes. DMA enables play no part.
- R6: Status bit 4n+2 (RX full) is set one clock after a cycle in which channel n is enabled, RX-full is high, its mode is not 2, turbo is low, and R4 passes.
- R7: A word_done_i pulse sets status bit 17 on the next clock.
- R8: Status bits stay set until cleared. In ST_RUN, a clr_wr_i cycle clears each bit written as one. A bit that is cleared and set in the same cycle ends up set.
- R9: An en_wr_i cycle loads irq_en_o with en_wdata_i AND 0x3777F. irq_o is high exactly when some bit is set in both irq_status_o and irq_en_o.
- R10: Starting at the second clock with sys_test_i high, irq_status_o reads 0x3777F. While in ST_TEST, clears have no effect.
- R11: After reset, the status, the mask, both request vectors and irq_o are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ch_en_i | input | NCH | Channel enable, one bit per channel |
| dma_tx_en_i | input | NCH | Transmit DMA enable per channel |
| dma_rx_en_i | input | NCH | Receive DMA enable per channel |
| xfer_mode_i | input | 2*NCH | Transfer mode, two bits per channel |
| tx_empty_i | input | NCH | Transmit register empty flag per channel |
| rx_full_i | input | NCH | Receive register full flag per channel |
| turbo_i | input | NCH | Turbo mode per channel |
| fifo_own_vld_i | input | 1 | Some channel owns the FIFO |
| fifo_own_ch_i | input | CH_W | Index of the FIFO owner |
| tx_fifo_en_i | input | 1 | Transmit FIFO enabled |
| rx_fifo_en_i | input | 1 | Receive FIFO enabled |
| tx_fifo_lvl_i | input | LVL_W | Transmit FIFO fill level |
| rx_fifo_lvl_i | input | LVL_W | Receive FIFO fill level |
| ae_thr_i | input | THR_W | Almost-empty level |
| af_thr_i | input | THR_W | Almost-full level |
| word_done_i | input | 1 | Word count reached pulse |
| sys_test_i | input | 1 | Diagnostic force mode |
| en_wr_i | input | 1 | Load interrupt mask |
| en_wdata_i | input | 18 | New interrupt mask |
| clr_wr_i | input | 1 | Write-one-to-clear strobe |
| clr_data_i | input | 18 | Bits to clear |
| tx_dreq_o | output | NCH | Transmit DMA request per channel |
| rx_dreq_o | output | NCH | Receive DMA request per channel |
| irq_status_o | output | 18 | Interrupt status |
| irq_en_o | output | 18 | Interrupt mask |
| irq_o | output | 1 | Interrupt line |

## Verification
Requests, status bits and the mask all appear one rising edge after the inputs that cause them. irq_o follows the registered status and mask within the same cycle. The force of the diagnostic mode lands on the second edge, because the sequencer state is registered first. The bench changes inputs on falling edges and compares on the following falling edge, or two falling edges later for the forced status. Before each new pattern it clears the status, so the expected value always comes from that one pattern alone.

// File: rtl/spi_dma_irq_pkg.sv
package spi_dma_irq_pkg;

    localparam int STAT_W  = 18;
    localparam int EOW_BIT = 17;

    typedef enum logic [0:0] {
        ST_RUN  = 1'b0,
        ST_TEST = 1'b1
    } irq_state_e;

    typedef enum logic [1:0] {
        MODE_FULL    = 2'd0,
        MODE_RX_ONLY = 2'd1,
        MODE_TX_ONLY = 2'd2,
        MODE_ALT     = 2'd3
    } xfer_mode_e;

    // Implemented status bits: three per channel, bit 3, bits 16 and 17.
    function automatic logic [STAT_W-1:0] impl_mask(input int nch);
        logic [STAT_W-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) begin
            m[4*i]   = 1'b1;
            m[4*i+1] = 1'b1;
            m[4*i+2] = 1'b1;
        end
        m[3]  = 1'b1;
        m[16] = 1'b1;
        m[17] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/spi_dreq_chan.sv
module spi_dreq_chan
    import spi_dma_irq_pkg::*;
#(
    parameter int LVL_W = 7,
    parameter int THR_W = 6
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             dtx_i,
    input  logic             drx_i,
    input  logic [1:0]       mode_i,
    input  logic             txs_i,
    input  logic             rxs_i,
    input  logic             turbo_i,
    input  logic             own_tx_i,
    input  logic             own_rx_i,
    input  logic [LVL_W-1:0] tx_lvl_i,
    input  logic [LVL_W-1:0] rx_lvl_i,
    input  logic [THR_W-1:0] ae_i,
    input  logic [THR_W-1:0] af_i,
    output logic             tx_evt_o,
    output logic             rx_evt_o,
    output logic             tx_dreq_o,
    output logic             rx_dreq_o
);

    logic tx_lvl_ok, rx_lvl_ok;
    logic tx_core, rx_core;

    always_comb begin
        tx_lvl_ok = !own_tx_i || (tx_lvl_i <= LVL_W'(ae_i));
        rx_lvl_ok = !own_rx_i || (rx_lvl_i >= LVL_W'(af_i));
        tx_core   = en_i && txs_i && (mode_i != MODE_RX_ONLY) && tx_lvl_ok;
        rx_core   = en_i && rxs_i && (mode_i != MODE_TX_ONLY) && rx_lvl_ok;
        tx_evt_o  = tx_core;
        rx_evt_o  = rx_core && !turbo_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tx_dreq_o <= 1'b0;
            rx_dreq_o <= 1'b0;
        end else begin
            tx_dreq_o <= tx_core && dtx_i;
            rx_dreq_o <= rx_core && drx_i;
        end
    end

    p_txreq_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_dreq_o |-> $past(en_i && dtx_i && txs_i && mode_i != MODE_RX_ONLY));
    p_rxreq_gate_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_dreq_o |-> $past(en_i && drx_i && rxs_i && mode_i != MODE_TX_ONLY));
    p_txreq_level_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_dreq_o |-> $past(!own_tx_i || tx_lvl_i <= LVL_W'(ae_i)));
    p_rxreq_level_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_dreq_o |-> $past(!own_rx_i || rx_lvl_i >= LVL_W'(af_i)));

endmodule

// File: rtl/spi_irq_status.sv
module spi_irq_status
    import spi_dma_irq_pkg::*;
#(
    parameter int NCH = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCH-1:0]    tx_evt_i,
    input  logic [NCH-1:0]    rx_evt_i,
    input  logic              word_done_i,
    input  logic              sys_test_i,
    input  logic              en_wr_i,
    input  logic [STAT_W-1:0] en_wdata_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    output logic [STAT_W-1:0] status_o,
    output logic [STAT_W-1:0] en_o,
    output logic              irq_o
);

    localparam logic [STAT_W-1:0] IMPL = impl_mask(NCH);

    irq_state_e        state_q, state_d;
    logic [STAT_W-1:0] stat_q, stat_d, set_vec, clr_eff, en_q;

    // Sequencer state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_RUN;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            ST_RUN:  state_d = sys_test_i ? ST_TEST : ST_RUN;
            ST_TEST: state_d = sys_test_i ? ST_TEST : ST_RUN;
        endcase
    end

    // Set sources
    always_comb begin
        set_vec = '0;
        for (int n = 0; n < NCH; n++) begin
            set_vec[4*n]   = tx_evt_i[n];
            set_vec[4*n+2] = rx_evt_i[n];
        end
        set_vec[EOW_BIT] = word_done_i;
        clr_eff = clr_wr_i ? clr_data_i : '0;
    end

    // Output process: next status per state
    always_comb begin
        unique case (state_q)
            ST_RUN:  stat_d = (stat_q & ~clr_eff) | set_vec;
            ST_TEST: stat_d = stat_q | IMPL | set_vec;
        endcase
        stat_d = stat_d & IMPL;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stat_q <= '0;
            en_q   <= '0;
        end else begin
            stat_q <= stat_d;
            if (en_wr_i) en_q <= en_wdata_i & IMPL;
        end
    end

    assign status_o = stat_q;
    assign en_o     = en_q;
    assign irq_o    = |(stat_q & en_q);

    p_eow_set_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        word_done_i |=> status_o[EOW_BIT]);
    p_clear_eow_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN && clr_wr_i && clr_data_i[EOW_BIT] && !word_done_i)
        |=> !status_o[EOW_BIT]);
    p_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!clr_wr_i) |=> ((status_o & $past(status_o)) == $past(status_o)));
    p_mask_load_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        en_wr_i |=> (en_o == ($past(en_wdata_i) & IMPL)));
    p_test_force_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_TEST) |=> ((status_o & IMPL) == IMPL));

endmodule

// File: rtl/spi_dma_irq_gen.sv
module spi_dma_irq_gen
    import spi_dma_irq_pkg::*;
#(
    parameter int NCH        = 4,
    parameter int FIFO_DEPTH = 64,
    parameter int THR_W      = 6,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1),
    localparam int CH_W      = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NCH-1:0]    ch_en_i,
    input  logic [NCH-1:0]    dma_tx_en_i,
    input  logic [NCH-1:0]    dma_rx_en_i,
    input  logic [2*NCH-1:0]  xfer_mode_i,
    input  logic [NCH-1:0]    tx_empty_i,
    input  logic [NCH-1:0]    rx_full_i,
    input  logic [NCH-1:0]    turbo_i,
    input  logic              fifo_own_vld_i,
    input  logic [CH_W-1:0]   fifo_own_ch_i,
    input  logic              tx_fifo_en_i,
    input  logic              rx_fifo_en_i,
    input  logic [LVL_W-1:0]  tx_fifo_lvl_i,
    input  logic [LVL_W-1:0]  rx_fifo_lvl_i,
    input  logic [THR_W-1:0]  ae_thr_i,
    input  logic [THR_W-1:0]  af_thr_i,
    input  logic              word_done_i,
    input  logic              sys_test_i,
    input  logic              en_wr_i,
    input  logic [STAT_W-1:0] en_wdata_i,
    input  logic              clr_wr_i,
    input  logic [STAT_W-1:0] clr_data_i,
    output logic [NCH-1:0]    tx_dreq_o,
    output logic [NCH-1:0]    rx_dreq_o,
    output logic [STAT_W-1:0] irq_status_o,
    output logic [STAT_W-1:0] irq_en_o,
    output logic              irq_o
);

    // NCH must stay within 1..4 so channel bits fit below bit 16.
    logic [NCH-1:0] tx_evt, rx_evt;

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic own;
        assign own = fifo_own_vld_i && (fifo_own_ch_i == CH_W'(n));

        spi_dreq_chan #(
            .LVL_W (LVL_W),
            .THR_W (THR_W)
        ) u_chan (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .en_i      (ch_en_i[n]),
            .dtx_i     (dma_tx_en_i[n]),
            .drx_i     (dma_rx_en_i[n]),
            .mode_i    (xfer_mode_i[2*n +: 2]),
            .txs_i     (tx_empty_i[n]),
            .rxs_i     (rx_full_i[n]),
            .turbo_i   (turbo_i[n]),
            .own_tx_i  (own && tx_fifo_en_i),
            .own_rx_i  (own && rx_fifo_en_i),
            .tx_lvl_i  (tx_fifo_lvl_i),
            .rx_lvl_i  (rx_fifo_lvl_i),
            .ae_i      (ae_thr_i),
            .af_i      (af_thr_i),
            .tx_evt_o  (tx_evt[n]),
            .rx_evt_o  (rx_evt[n]),
            .tx_dreq_o (tx_dreq_o[n]),
            .rx_dreq_o (rx_dreq_o[n])
        );
    end

    spi_irq_status #(
        .NCH (NCH)
    ) u_stat (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .tx_evt_i    (tx_evt),
        .rx_evt_i    (rx_evt),
        .word_done_i (word_done_i),
        .sys_test_i  (sys_test_i),
        .en_wr_i     (en_wr_i),
        .en_wdata_i  (en_wdata_i),
        .clr_wr_i    (clr_wr_i),
        .clr_data_i  (clr_data_i),
        .status_o    (irq_status_o),
        .en_o        (irq_en_o),
        .irq_o       (irq_o)
    );

endmodule

// File: tb/spi_dma_irq_gen_bench.sv
module spi_dma_irq_gen_bench;

    localparam int NCH = 4;
    localparam int LVL_W = 7;
    localparam int THR_W = 6;
    localparam int SW = 18;
    localparam logic [SW-1:0] LEGAL = 18'h3777F;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NCH-1:0] ch_en, dtx, drx, txs, rxs, turbo;
    logic [2*NCH-1:0] mode;
    logic own_vld, tfe, rfe, word_done, sys_test, en_wr, clr_wr;
    logic [1:0] own_ch;
    logic [LVL_W-1:0] tlvl, rlvl;
    logic [THR_W-1:0] ae, af;
    logic [SW-1:0] en_wdata, clr_data;
    logic [NCH-1:0] tx_dreq, rx_dreq;
    logic [SW-1:0] status, irq_en;
    logic irq;

    int checks = 0;
    int fails = 0;
    logic [SW-1:0] mask_exp = '0;

    always #2 clk = ~clk;

    spi_dma_irq_gen u_spi_dma_irq_gen (
        .clk_i(clk), .rst_ni(rst_n), .ch_en_i(ch_en), .dma_tx_en_i(dtx),
        .dma_rx_en_i(drx), .xfer_mode_i(mode), .tx_empty_i(txs),
        .rx_full_i(rxs), .turbo_i(turbo), .fifo_own_vld_i(own_vld),
        .fifo_own_ch_i(own_ch), .tx_fifo_en_i(tfe), .rx_fifo_en_i(rfe),
        .tx_fifo_lvl_i(tlvl), .rx_fifo_lvl_i(rlvl), .ae_thr_i(ae),
        .af_thr_i(af), .word_done_i(word_done), .sys_test_i(sys_test),
        .en_wr_i(en_wr), .en_wdata_i(en_wdata), .clr_wr_i(clr_wr),
        .clr_data_i(clr_data), .tx_dreq_o(tx_dreq), .rx_dreq_o(rx_dreq),
        .irq_status_o(status), .irq_en_o(irq_en), .irq_o(irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic tx_ok(input int n);
        logic own = own_vld && own_ch == 2'(n) && tfe;
        return ch_en[n] && txs[n] && mode[2*n +: 2] != 2'd1 && (!own || tlvl <= LVL_W'(ae));
    endfunction

    function automatic logic rx_ok(input int n);
        logic own = own_vld && own_ch == 2'(n) && rfe;
        return ch_en[n] && rxs[n] && mode[2*n +: 2] != 2'd2 && (!own || rlvl >= LVL_W'(af));
    endfunction

    task automatic check_all(input string tag);
        logic [NCH-1:0] etx, erx;
        logic [SW-1:0] est;
        est = '0;
        for (int n = 0; n < NCH; n++) begin
            etx[n] = tx_ok(n) && dtx[n];
            erx[n] = rx_ok(n) && drx[n];
            est[4*n] = tx_ok(n);
            est[4*n+2] = rx_ok(n) && !turbo[n];
        end
        check({tag, " R1 R3 tx_dreq"}, 32'(tx_dreq), 32'(etx));
        check({tag, " R2 R4 rx_dreq"}, 32'(rx_dreq), 32'(erx));
        check({tag, " R5 R6 status"}, 32'(status), 32'(est));
        check({tag, " R9 irq"}, 32'(irq), 32'(|(est & mask_exp)));
    endtask

    task automatic idle();
        ch_en = '0; dtx = '0; drx = '0; txs = '0; rxs = '0; turbo = '0; mode = '0;
        word_done = 1'b0; sys_test = 1'b0; en_wr = 1'b0; clr_wr = 1'b0;
    endtask

    task automatic clear_all();
        idle();
        clr_wr = 1'b1; clr_data = '1;
        @(negedge clk);
        clr_wr = 1'b0;
    endtask

    task automatic apply_combo(input int c, input int n);
        ch_en[n] = c[0]; dtx[n] = c[1]; drx[n] = c[2];
        mode[2*n +: 2] = c[4:3]; txs[n] = c[5]; rxs[n] = c[6]; turbo[n] = c[7];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        idle();
        own_vld = 1'b0; own_ch = '0; tfe = 1'b0; rfe = 1'b0;
        tlvl = '0; rlvl = '0; ae = '0; af = '0; en_wdata = '0; clr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 status", 32'(status), 0);
        check("R11 mask", 32'(irq_en), 0);
        check("R11 dreq", 32'({tx_dreq, rx_dreq}), 0);
        check("R11 irq", 32'(irq), 0);

        // R9 mask load, illegal bits dropped
        en_wr = 1'b1; en_wdata = '1;
        @(negedge clk);
        en_wr = 1'b0; mask_exp = LEGAL;
        check("R9 mask legal bits", 32'(irq_en), 32'(LEGAL));

        // R1 R2 R5 R6 sweep of per-channel conditions, no FIFO owner
        for (int c = 0; c < 256; c++) begin
            clear_all();
            for (int n = 0; n < NCH; n++) apply_combo((c + 37 * n) % 256, n);
            @(negedge clk);
            check_all("sweep");
        end

        // R3 R4 FIFO levels against thresholds, owner channel 1
        own_vld = 1'b1; own_ch = 2'd1;
        for (int f = 0; f < 4; f++) begin
            foreach (ae[i]) ;
            for (int t = 0; t < 3; t++) begin
                for (int l = 0; l <= 64; l++) begin
                    clear_all();
                    tfe = f[0]; rfe = f[1];
                    ae = (t == 0) ? 6'd0 : (t == 1) ? 6'd9 : 6'd63;
                    af = ae;
                    tlvl = 7'(l); rlvl = 7'(64 - l);
                    ch_en = '1; dtx = '1; drx = '1; txs = '1; rxs = '1;
                    @(negedge clk);
                    check_all("level");
                end
            end
        end
        own_vld = 1'b0; tfe = 1'b0; rfe = 1'b0;

        // R7 end-of-count bit
        clear_all();
        word_done = 1'b1;
        @(negedge clk);
        word_done = 1'b0;
        check("R7 eow set", 32'(status), 32'(18'h20000));
        // R8 clearing another bit leaves bit 17
        clr_wr = 1'b1; clr_data = 18'h00001;
        @(negedge clk);
        check("R8 unrelated clear", 32'(status), 32'(18'h20000));
        clr_data = 18'h20000;
        @(negedge clk);
        clr_wr = 1'b0;
        check("R8 w1c clears", 32'(status), 0);

        // R8 set beats clear in the same cycle
        ch_en[0] = 1'b1; rxs[0] = 1'b1; clr_wr = 1'b1; clr_data = '1;
        @(negedge clk);
        check("R8 set wins", 32'(status), 32'(18'h00004));
        clear_all();
        check("R8 cleared after", 32'(status), 0);

        // R9 narrow mask: only bit 2 reaches the line
        en_wr = 1'b1; en_wdata = 18'h00084;
        @(negedge clk);
        en_wr = 1'b0; mask_exp = 18'h00004;
        check("R9 mask narrow", 32'(irq_en), 32'(18'h00004));
        ch_en[0] = 1'b1; txs[0] = 1'b1;
        @(negedge clk);
        check("R9 masked bit no irq", 32'(irq), 0);
        check("R5 tx bit set", 32'(status), 32'(18'h00001));
        rxs[0] = 1'b1;
        @(negedge clk);
        check("R9 enabled bit irq", 32'(irq), 1);

        // R10 diagnostic force
        clear_all();
        sys_test = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 forced", 32'(status), 32'(LEGAL));
        clr_wr = 1'b1; clr_data = '1;
        @(negedge clk);
        check("R10 clear ignored", 32'(status), 32'(LEGAL));
        clr_wr = 1'b0; sys_test = 1'b0;
        @(negedge clk);
        check("R10 held leaving", 32'(status), 32'(LEGAL));
        clear_all();
        check("R10 clear after exit", 32'(status), 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule